// File: doc/BRIEF.md
# Telemetry Acquisition Sequencer with Dual Result Table

This block walks a software-programmed list of analogue telemetry channels. For each list step it drives the front-end multiplexer select and the per-channel single-ended/bias controls. It then waits a programmable number of settling cycles so that the analogue path can stabilise after the switch. After that it pulses a conversion request and waits for a conversion-done strobe that qualifies the converted value.

Every channel owns two result slots. One slot latches the first sample taken since the channel was armed. The other is overwritten by every new sample. Software configures the block and reads the table through a simple synchronous register bus, of the kind an SPI slave front end would drive. A run either makes one pass over the list or wraps around to the start and repeats until it is stopped. If the converter does not answer in time, a sticky error flag is set and the sequence moves on.

Register map, 10-bit address, 32-bit data:

| Address | Name | Contents |
|---|---|---|
| 0x000 | CTRL | Writing bit0=1 starts a run. Writing bit0=0 stops a run. Bit1 selects loop mode. On read, bit0 is busy and bit1 is loop. |
| 0x001 | LEN | Number of list entries. Values above 54 are clamped to 54. |
| 0x002 | SETTLE | Settling cycles. |
| 0x003 | TIMEOUT | Conversion timeout in cycles. |
| 0x004 | STATUS | Bit0 is busy. Bit1 is the sticky timeout error; writing 1 to bit1 clears it. |
| 0x100+i | List entry i | Channel index of list entry i. |
| 0x200+c | Channel config | Bit0 marks channel c single-ended. Bit1 requests its bias current. |
| 0x300+2c+s | Result | Slot s of channel c, with s=0 the first sample and s=1 the latest. On read, bits [15:0] are the value and bit16 is the valid flag. |

Top module: `tlm_seq_top`

## Requirements
- R1: After reset, muxSel is 0, convStart is 0, biasEn is 0, STATUS reads 0 and every result slot reads with valid bit16 clear.
- R2: The k-th acquisition of a run drives muxSel with list entry k, counted from entry 0. The converted value is stored under that channel.
- R3: convStart is a one-cycle pulse that rises exactly SETTLE+1 clock cycles after muxSel takes the new channel, and muxSel holds during the pulse.
- R4: A convDone in the wait phase writes convData to the latest slot (0x300+2c+1) with bit16 set. It writes the first slot (0x300+2c) only while that slot's valid bit is clear.
- R5: Any write to a first-slot address clears that slot's valid bit, and the next sample of that channel refills it. The latest slot is left unchanged.
- R6: With CTRL bit1=0, a run ends after LEN acquisitions: STATUS bit0 reads 0 and no further convStart occurs.
- R7: With CTRL bit1=1, the list wraps from entry LEN-1 back to entry 0 and acquisition continues.
- R8: If no convDone arrives within TIMEOUT+1 cycles after the conversion request, STATUS bit1 is set, the table entry is not written and the sequence advances. Writing STATUS with bit1=1 clears the flag.
- R9: seMode follows bit0 of the selected channel's config. biasEn is high only while a run is active and the selected channel has both bit0 and bit1 set.
- R10: A read of a result slot in the same cycle that the slot is written returns the new value with bit16 set.
- R11: Starting with LEN=0 leaves the block idle with no convStart.
- R12: Writing CTRL with bit0=0 during a run returns the block to idle on the next edge, with no further convStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 10 | Register bus address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| muxSel | output | 6 | Channel select to the analogue multiplexer |
| seMode | output | 1 | Selected channel is single-ended |
| biasEn | output | 1 | Bias current source enable for the selected channel |
| convStart | output | 1 | One-cycle conversion request |
| convDone | input | 1 | Conversion result valid strobe |
| convData | input | 16 | Converted telemetry value |

## Verification
The main pass uses a list that visits the same channel twice and a second channel at a distance. Only correct first/latest separation yields the expected pair in each slot, and a reversed list order would put the values under the wrong channels. During that pass each write cycle is also read back through the bus, which separates the bypass path from a plain registered read. Further directed runs each isolate one behaviour: a long settle value measured to the cycle, a converter that never answers, a loop list seen wrapping, a stop during settling, a re-armed slot, a zero-length start, and a bias-capable channel left selected after the run so that the busy gating of biasEn shows.

// File: rtl/tlm_seq_pkg.sv
package tlm_seq_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_START,
    ST_WAIT
  } seqState_t;

  // Strobes from the sequencing control to the table datapath
  typedef struct packed {
    logic wrResult;
    logic setTimeout;
  } seqStrobe_t;
endpackage

// File: rtl/tlm_seq_ctrl.sv
module tlm_seq_ctrl
  import tlm_seq_pkg::*;
#(
  parameter int CH_W   = 6,
  parameter int IDX_W  = 6,
  parameter int LEN_W  = 6,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic              loopMode,
  input  logic [LEN_W-1:0]  seqLen,
  input  logic [TIME_W-1:0] settleCyc,
  input  logic [TIME_W-1:0] timeoutCyc,
  input  logic [CH_W-1:0]   seqCh,
  input  logic              convDone,
  output logic [IDX_W-1:0]  seqIdx,
  output logic [CH_W-1:0]   curCh,
  output logic              convStart,
  output logic              busy,
  output seqStrobe_t        strobe
);
  timeunit 1ns;
  timeprecision 1ps;

  seqState_t         state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  nextIdx;
  logic [TIME_W-1:0] cnt;
  logic              lastStep;
  logic              stepDone;

  assign lastStep  = (LEN_W'(idx) + LEN_W'(1)) == seqLen;
  assign nextIdx   = lastStep ? '0 : idx + IDX_W'(1);
  assign seqIdx    = (state == ST_IDLE) ? '0 : nextIdx;
  assign convStart = (state == ST_START);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strobe.wrResult   = (state == ST_WAIT) && convDone && !stopReq;
    strobe.setTimeout = (state == ST_WAIT) && !convDone && (cnt == timeoutCyc) && !stopReq;
  end
  assign stepDone = strobe.wrResult || strobe.setTimeout;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      curCh <= '0;
      cnt   <= '0;
    end else if (stopReq && state != ST_IDLE) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq && seqLen != '0) begin
            state <= ST_SETTLE;
            idx   <= '0;
            curCh <= seqCh;
            cnt   <= '0;
          end
        end
        ST_SETTLE: begin
          if (cnt == settleCyc) state <= ST_START;
          else                  cnt   <= cnt + TIME_W'(1);
        end
        ST_START: begin
          state <= ST_WAIT;
          cnt   <= '0;
        end
        ST_WAIT: begin
          if (stepDone) begin
            if (lastStep && !loopMode) begin
              state <= ST_IDLE;
            end else begin
              state <= ST_SETTLE;
              idx   <= nextIdx;
              curCh <= seqCh;
              cnt   <= '0;
            end
          end else begin
            cnt <= cnt + TIME_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tlm_seq_dp.sv
module tlm_seq_dp
  import tlm_seq_pkg::*;
#(
  parameter int NUM_CH    = 54,
  parameter int SEQ_DEPTH = 54,
  parameter int DATA_W    = 16,
  parameter int TIME_W    = 16,
  parameter int ADDR_W    = 10,
  parameter int BUS_W     = 32,
  parameter int CH_W      = 6,
  parameter int IDX_W     = 6,
  parameter int LEN_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  input  logic [IDX_W-1:0]  seqIdx,
  output logic [CH_W-1:0]   seqCh,
  input  logic [CH_W-1:0]   curCh,
  input  logic              busy,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] convData,
  output logic              startReq,
  output logic              stopReq,
  output logic              loopMode,
  output logic [LEN_W-1:0]  seqLen,
  output logic [TIME_W-1:0] settleCyc,
  output logic [TIME_W-1:0] timeoutCyc,
  output logic              seMode,
  output logic              biasEn
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int OFF_W = ADDR_W - 2;

  logic [1:0]       region;
  logic [OFF_W-1:0] off;
  logic [CH_W-1:0]  rCh;
  logic             ctlWe;
  logic             curValid;

  logic [CH_W-1:0]   seqList [SEQ_DEPTH];
  logic [1:0]        chCfg   [NUM_CH];
  logic [DATA_W-1:0] firstArr [NUM_CH];
  logic [DATA_W-1:0] lastArr  [NUM_CH];
  logic              firstVld [NUM_CH];
  logic              lastVld  [NUM_CH];
  logic              errReg;

  assign region   = regAddr[ADDR_W-1 -: 2];
  assign off      = regAddr[OFF_W-1:0];
  assign rCh      = off[CH_W:1];
  assign ctlWe    = regWe && (region == 2'd0);
  assign startReq = ctlWe && (off == OFF_W'(0)) && regWdata[0];
  assign stopReq  = ctlWe && (off == OFF_W'(0)) && !regWdata[0];
  assign seqCh    = seqList[seqIdx];

  assign curValid = curCh < CH_W'(NUM_CH);
  assign seMode   = curValid && chCfg[curCh][0];
  assign biasEn   = curValid && busy && chCfg[curCh][0] && chCfg[curCh][1];

  // Configuration registers, list and channel setup
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopMode   <= 1'b0;
      seqLen     <= '0;
      settleCyc  <= '0;
      timeoutCyc <= '1;
      errReg     <= 1'b0;
      for (int i = 0; i < SEQ_DEPTH; i++) seqList[i] <= '0;
      for (int i = 0; i < NUM_CH; i++)    chCfg[i]   <= '0;
    end else begin
      if (ctlWe) begin
        case (off)
          OFF_W'(0): loopMode   <= regWdata[1];
          OFF_W'(1): seqLen     <= (regWdata > BUS_W'(SEQ_DEPTH)) ? LEN_W'(SEQ_DEPTH)
                                                                 : LEN_W'(regWdata);
          OFF_W'(2): settleCyc  <= regWdata[TIME_W-1:0];
          OFF_W'(3): timeoutCyc <= regWdata[TIME_W-1:0];
          default: ;
        endcase
      end
      if (regWe && region == 2'd1 && off < OFF_W'(SEQ_DEPTH))
        seqList[off[IDX_W-1:0]] <= regWdata[CH_W-1:0];
      if (regWe && region == 2'd2 && off < OFF_W'(NUM_CH))
        chCfg[off[CH_W-1:0]] <= regWdata[1:0];
      if (strobe.setTimeout)
        errReg <= 1'b1;
      else if (ctlWe && off == OFF_W'(4) && regWdata[1])
        errReg <= 1'b0;
    end
  end

  // Two-slot result entry per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_entry
    logic [DATA_W-1:0] firstVal, lastVal;
    logic              firstOk, lastOk;
    logic              hitWr, hitArm;

    assign hitWr  = strobe.wrResult && (curCh == CH_W'(c));
    assign hitArm = regWe && (region == 2'd3) && !off[0] && (rCh == CH_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        firstVal <= '0;
        lastVal  <= '0;
        firstOk  <= 1'b0;
        lastOk   <= 1'b0;
      end else begin
        if (hitWr) begin
          lastVal <= convData;
          lastOk  <= 1'b1;
          if (!firstOk) begin
            firstVal <= convData;
            firstOk  <= 1'b1;
          end
        end
        if (hitArm) firstOk <= 1'b0;
      end
    end

    assign firstArr[c] = firstVal;
    assign lastArr[c]  = lastVal;
    assign firstVld[c] = firstOk;
    assign lastVld[c]  = lastOk;
  end

  // Read mux with same-cycle write bypass on the result table
  always_comb begin
    logic              hit;
    logic [DATA_W-1:0] val;
    logic              vld;
    regRdata = '0;
    hit      = 1'b0;
    val      = '0;
    vld      = 1'b0;
    case (region)
      2'd0: begin
        case (off)
          OFF_W'(0): regRdata = BUS_W'({loopMode, busy});
          OFF_W'(1): regRdata = BUS_W'(seqLen);
          OFF_W'(2): regRdata = BUS_W'(settleCyc);
          OFF_W'(3): regRdata = BUS_W'(timeoutCyc);
          OFF_W'(4): regRdata = BUS_W'({errReg, busy});
          default:   regRdata = '0;
        endcase
      end
      2'd1: if (off < OFF_W'(SEQ_DEPTH)) regRdata = BUS_W'(seqList[off[IDX_W-1:0]]);
      2'd2: if (off < OFF_W'(NUM_CH))    regRdata = BUS_W'(chCfg[off[CH_W-1:0]]);
      default: begin
        if (rCh < CH_W'(NUM_CH)) begin
          hit = strobe.wrResult && (curCh == rCh);
          if (off[0]) begin
            val = hit ? convData : lastArr[rCh];
            vld = hit || lastVld[rCh];
          end else if (hit && !firstVld[rCh]) begin
            val = convData;
            vld = 1'b1;
          end else begin
            val = firstArr[rCh];
            vld = firstVld[rCh];
          end
          regRdata = BUS_W'({vld, val});
        end
      end
    endcase
  end
endmodule

// File: rtl/tlm_seq_top.sv
module tlm_seq_top
  import tlm_seq_pkg::*;
#(
  parameter int NUM_CH    = 54,
  parameter int SEQ_DEPTH = 54,
  parameter int DATA_W    = 16,
  parameter int TIME_W    = 16,
  parameter int ADDR_W    = 10,
  parameter int BUS_W     = 32,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int IDX_W    = $clog2(SEQ_DEPTH),
  localparam int LEN_W    = $clog2(SEQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [BUS_W-1:0]  regWdata,
  output logic [BUS_W-1:0]  regRdata,
  output logic [CH_W-1:0]   muxSel,
  output logic              seMode,
  output logic              biasEn,
  output logic              convStart,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData
);
  timeunit 1ns;
  timeprecision 1ps;

  logic              startReq, stopReq, loopMode, busyInt;
  logic [LEN_W-1:0]  seqLen;
  logic [TIME_W-1:0] settleCyc, timeoutCyc;
  logic [IDX_W-1:0]  seqIdx;
  logic [CH_W-1:0]   seqCh;
  seqStrobe_t        strobe;

  tlm_seq_ctrl #(
    .CH_W(CH_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .TIME_W(TIME_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .startReq(startReq), .stopReq(stopReq), .loopMode(loopMode),
    .seqLen(seqLen), .settleCyc(settleCyc), .timeoutCyc(timeoutCyc),
    .seqCh(seqCh), .convDone(convDone),
    .seqIdx(seqIdx), .curCh(muxSel), .convStart(convStart),
    .busy(busyInt), .strobe(strobe)
  );

  tlm_seq_dp #(
    .NUM_CH(NUM_CH), .SEQ_DEPTH(SEQ_DEPTH), .DATA_W(DATA_W), .TIME_W(TIME_W),
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CH_W(CH_W), .IDX_W(IDX_W), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .seqIdx(seqIdx), .seqCh(seqCh), .curCh(muxSel), .busy(busyInt),
    .strobe(strobe), .convData(convData),
    .startReq(startReq), .stopReq(stopReq), .loopMode(loopMode),
    .seqLen(seqLen), .settleCyc(settleCyc), .timeoutCyc(timeoutCyc),
    .seMode(seMode), .biasEn(biasEn)
  );
endmodule

// File: rtl/tlm_seq_chk.sv
module tlm_seq_chk
  import tlm_seq_pkg::*;
#(
  parameter int CH_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            convStart,
  input logic            convDone,
  input logic [CH_W-1:0] muxSel,
  input logic            busyInt,
  input logic            seMode,
  input logic            biasEn,
  input seqStrobe_t      strobe
);
  timeunit 1ns;
  timeprecision 1ps;

  // R3: the request is a single-cycle pulse
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R3: the select does not move across the request
  p_mux_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> $stable(muxSel));

  // R6: no request while the sequencer is idle
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> busyInt);

  // R4: a table write is always backed by a done strobe
  p_write_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrResult |-> convDone);

  // R8: a timed-out step never also writes the table
  p_timeout_nowrite_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setTimeout |-> !strobe.wrResult);

  // R9: bias only on a single-ended channel during a run
  p_bias_se_r9: assert property (@(posedge clk) disable iff (!rstN)
    biasEn |-> (seMode && busyInt));
endmodule

bind tlm_seq_top tlm_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .convStart(convStart), .convDone(convDone),
  .muxSel(muxSel), .busyInt(busyInt), .seMode(seMode), .biasEn(biasEn),
  .strobe(strobe)
);

// File: tb/test_tlm_seq_top.sv
module test_tlm_seq_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [9:0] A_CTRL = 10'h000, A_LEN = 10'h001, A_SETTLE = 10'h002,
                         A_TOUT = 10'h003, A_STAT = 10'h004;

  typedef struct packed {
    logic [5:0]  ch;
    logic [15:0] data;
    logic [15:0] expFirst;
    logic [15:0] expLast;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    '{6'd3,  16'h1111, 16'h1111, 16'h3333},
    '{6'd10, 16'h2222, 16'h2222, 16'h5555},
    '{6'd3,  16'h3333, 16'h1111, 16'h3333},
    '{6'd53, 16'h4444, 16'h4444, 16'h4444},
    '{6'd10, 16'h5555, 16'h2222, 16'h5555}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [9:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [5:0]  muxSel;
  logic        seMode, biasEn, convStart;
  logic        convDone = 1'b0;
  logic [15:0] convData = '0;

  int checks = 0;
  int errors = 0;

  tlm_seq_top i_tlm_seq_top (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .muxSel(muxSel),
    .seMode(seMode), .biasEn(biasEn), .convStart(convStart),
    .convDone(convDone), .convData(convData)
  );

  always #10 clk = ~clk;

  function automatic logic [9:0] resAddr(input logic [5:0] ch, input logic slot);
    return 10'h300 + {3'b000, ch, slot};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitStart();
    while (!convStart) @(negedge clk);
  endtask

  task automatic finishConv(input logic [15:0] d);
    @(negedge clk);
    convDone = 1'b1; convData = d;
    @(negedge clk);
    convDone = 1'b0;
  endtask

  task automatic countStarts(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (convStart) n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 muxSel", 32'(muxSel), 32'd0);
    check("R1 convStart", 32'(convStart), 32'd0);
    check("R1 biasEn", 32'(biasEn), 32'd0);
    regRead(A_STAT, rd);              check("R1 status", rd, 32'd0);
    regRead(resAddr(6'd0, 1'b1), rd); check("R1 result invalid", rd, 32'd0);

    // Vector pass: order R2, first/latest R4, bypass R10
    for (int i = 0; i < NVEC; i++) regWrite(10'h100 + 10'(i), 32'(VEC[i].ch));
    regWrite(A_SETTLE, 32'd3);
    regWrite(A_TOUT, 32'd100);
    regWrite(A_LEN, 32'(NVEC));
    regWrite(A_CTRL, 32'd1);
    for (int i = 0; i < NVEC; i++) begin
      waitStart();
      check("R2 channel order", 32'(muxSel), 32'(VEC[i].ch));
      @(negedge clk);
      convDone = 1'b1; convData = VEC[i].data;
      regAddr = resAddr(VEC[i].ch, 1'b1);
      #1 check("R10 bypass read", regRdata, {15'd0, 1'b1, VEC[i].data});
      @(negedge clk);
      convDone = 1'b0;
    end
    regRead(A_STAT, rd); check("R6 single pass ends", rd, 32'd0);
    countStarts(20, n);  check("R6 no extra start", 32'(n), 32'd0);
    for (int i = 0; i < NVEC; i++) begin
      regRead(resAddr(VEC[i].ch, 1'b0), rd);
      check("R4 first slot", rd, {15'd0, 1'b1, VEC[i].expFirst});
      regRead(resAddr(VEC[i].ch, 1'b1), rd);
      check("R4 latest slot", rd, {15'd0, 1'b1, VEC[i].expLast});
    end

    // R3 settling delay measured to the cycle
    regWrite(10'h100, 32'd20);
    regWrite(A_LEN, 32'd1);
    regWrite(A_SETTLE, 32'd7);
    regWrite(A_CTRL, 32'd1);
    check("R3 mux switched", 32'(muxSel), 32'd20);
    n = 0;
    while (!convStart) begin @(negedge clk); n++; end
    check("R3 settle cycles", 32'(n), 32'd8);
    finishConv(16'hABCD);
    regWrite(A_SETTLE, 32'd2);

    // R5 re-arm of the first slot
    regWrite(resAddr(6'd3, 1'b0), 32'd0);
    regRead(resAddr(6'd3, 1'b0), rd); check("R5 rearm clears valid", rd, 32'h0000_1111);
    regRead(resAddr(6'd3, 1'b1), rd); check("R5 latest kept", rd, 32'h0001_3333);
    regWrite(10'h100, 32'd3);
    regWrite(A_CTRL, 32'd1);
    waitStart();
    finishConv(16'h7777);
    regRead(resAddr(6'd3, 1'b0), rd); check("R5 refill first", rd, 32'h0001_7777);

    // R8 timeout: no answer from the converter
    regWrite(10'h100, 32'd40);
    regWrite(A_TOUT, 32'd4);
    regWrite(A_CTRL, 32'd1);
    repeat (30) @(negedge clk);
    regRead(A_STAT, rd);               check("R8 error set, run ended", rd, 32'd2);
    regRead(resAddr(6'd40, 1'b1), rd); check("R8 no table write", rd, 32'd0);
    regWrite(A_STAT, 32'd2);
    regRead(A_STAT, rd);               check("R8 error cleared", rd, 32'd0);
    regWrite(A_TOUT, 32'd100);

    // R7 loop mode wraps, then R12 stop
    regWrite(10'h100, 32'd1);
    regWrite(10'h101, 32'd2);
    regWrite(A_LEN, 32'd2);
    regWrite(A_CTRL, 32'd3);
    waitStart(); check("R7 loop step0", 32'(muxSel), 32'd1); finishConv(16'h0101);
    waitStart(); check("R7 loop step1", 32'(muxSel), 32'd2); finishConv(16'h0202);
    waitStart(); check("R7 loop wraps", 32'(muxSel), 32'd1); finishConv(16'h0303);
    regWrite(A_CTRL, 32'd0);
    regRead(A_STAT, rd); check("R12 stop idles", rd, 32'd0);
    countStarts(20, n);  check("R12 no start after stop", 32'(n), 32'd0);

    // R9 single-ended flag and bias gating
    regWrite(10'h205, 32'd3);
    regWrite(10'h206, 32'd2);
    regWrite(10'h100, 32'd6);
    regWrite(10'h101, 32'd5);
    regWrite(A_CTRL, 32'd1);
    waitStart();
    check("R9 diff seMode", 32'(seMode), 32'd0);
    check("R9 diff no bias", 32'(biasEn), 32'd0);
    finishConv(16'h0606);
    waitStart();
    check("R9 se seMode", 32'(seMode), 32'd1);
    check("R9 se bias on", 32'(biasEn), 32'd1);
    finishConv(16'h0505);
    @(negedge clk);
    check("R9 bias off when idle", 32'(biasEn), 32'd0);
    check("R9 seMode follows channel", 32'(seMode), 32'd1);

    // R11 zero length start
    regWrite(A_LEN, 32'd0);
    regWrite(A_CTRL, 32'd1);
    regRead(A_STAT, rd); check("R11 zero length idle", rd, 32'd0);
    countStarts(10, n);  check("R11 no start", 32'(n), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule